// File: doc/BRIEF.md
# Threshold Triggered Burst Capture Gate

This block sits behind an ADC that delivers one sample per strobe and decides when a signal burst is on the line. While it waits it drops every sample whose level does not exceed a start threshold. The first sample above that level opens a capture. From that sample on, every strobed sample is written, in arrival order, to an external capture buffer through a simple write port.

To detect the end of the burst, the gate keeps a running sum over a six-sample window. The window holds the incoming sample and the five stored samples just before it. Once the window is full and its sum falls below a stop threshold, the capture closes. The gate then reports the number of stored samples together with a completion flag, for the demodulator downstream. If the buffer fills before the energy drops, the capture closes with an overflow flag. A finished capture is held until a rearm pulse clears it. Both thresholds are run-time inputs. The stop threshold is three bits wider than a sample so that it can span a full window sum. In a typical link the strobe runs at four samples per bit.

Top module: `burst_capture_gate`

## Requirements
- R1: While idle, a valid sample whose unsigned value is less than or equal to `start_lvl` is not written, the count stays 0 and no flag is raised.
- R2: A valid sample strictly greater than `start_lvl` while idle opens a capture. That sample is written at address 0, and each later valid sample is written at the next address. `wr_en`, `wr_addr` and `wr_data` appear one clock after the sample is accepted, and `cap_count` then equals the number of samples stored.
- R3: A cycle with `smp_valid` low stores nothing and does not move the count or the window, in any state.
- R4: For each stored sample the window sum is that sample plus the five previously stored samples of the current capture, with missing ones counted as zero. When the sum is unsigned less than `stop_lvl`, that sample is the last one stored, and one clock later `cap_done` is 1 and `cap_count` holds the total.
- R5: The stop comparison applies only to a sample that is the sixth or a later one stored, so no capture ends by threshold with fewer than six samples.
- R6: If the DEPTH-th sample is stored without meeting the stop condition, the capture ends with `cap_done` and `cap_ovf` both 1 and `cap_count` equal to DEPTH. If the stop condition is met on that same sample, `cap_ovf` stays 0.
- R7: After completion, further samples of any level are not written, and `cap_count`, `cap_done` and `cap_ovf` hold their values.
- R8: A cycle with `rearm` high returns the gate to idle. One clock later the count is 0, both flags are 0 and the window is empty. A sample presented in the same cycle as `rearm` is dropped. A rearm during a capture abandons it.
- R9: During and right after synchronous reset, `wr_en`, `cap_count`, `cap_done` and `cap_ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Unsigned ADC sample |
| start_lvl | input | SAMPLE_W | Start threshold; a sample must exceed it |
| stop_lvl | input | SAMPLE_W+3 | Stop threshold for the six-sample sum |
| rearm | input | 1 | Return to idle and clear the result |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | clog2(DEPTH) | Buffer write address |
| wr_data | output | SAMPLE_W | Buffer write data |
| cap_count | output | clog2(DEPTH+1) | Number of samples stored |
| cap_done | output | 1 | Capture complete |
| cap_ovf | output | 1 | Capture ended because the buffer filled |

## Verification
The bench targets the strict comparisons: a sample equal to the start threshold must not open a capture, and a window sum equal to the stop threshold must not close one. A design using inclusive compares would capture idle noise or cut a burst one sample short. A stop-level sweep over many burst shapes catches stops taken before the window is full, which would give counts below six, and window sums that mix in samples from an earlier capture because rearm did not clear the history. A crafted burst whose stop lands on exactly the last buffer slot separates stop-over-overflow priority from the reverse. Dropped invalid cycles, samples arriving after completion and a rearm that coincides with a sample check that nothing is written and that the held count does not drift.

// File: rtl/capgate_pkg.sv
package capgate_pkg;

    // Length of the energy window used for the stop decision.
    localparam int unsigned WIN_LEN = 6;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_HELD = 2'd2
    } phase_e;

    // Bits needed to hold the sum of win unsigned samples of sw bits.
    function automatic int unsigned sum_width(input int unsigned sw, input int unsigned win);
        return sw + $clog2(win);
    endfunction

endpackage

// File: rtl/capgate_window.sv
module capgate_window #(
    parameter int unsigned SW    = 12,
    parameter int unsigned WIN   = 6,
    parameter int unsigned SUM_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [SW-1:0]    din,
    output logic [SUM_W-1:0] sum_o
);
    localparam int unsigned HIST = WIN - 1;

    // hist[0] is the most recently stored sample
    logic [SW-1:0]    hist [HIST];
    logic [SUM_W-1:0] run_q;

    for (genvar i = 0; i < HIST; i++) begin : g_hist
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                hist[i] <= '0;
            end else if (push) begin
                if (i == 0) hist[i] <= din;
                else        hist[i] <= hist[(i == 0) ? 0 : i-1];
            end
        end
    end

    // Running total of the stored history, updated by add-new / drop-oldest.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_q <= '0;
        end else if (push) begin
            run_q <= run_q + SUM_W'(din) - SUM_W'(hist[HIST-1]);
        end
    end

    assign sum_o = run_q + SUM_W'(din);

    // The history total never exceeds what HIST full-scale samples could reach.
    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        run_q <= SUM_W'(HIST * ((1 << SW) - 1)));  // R4

endmodule

// File: rtl/capgate_ctrl.sv
module capgate_ctrl
    import capgate_pkg::*;
#(
    parameter int unsigned SW    = 12,
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned WIN   = 6,
    parameter int unsigned SUM_W = 15,
    parameter int unsigned AW    = 11,
    parameter int unsigned CW    = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rearm,
    input  logic             smp_valid,
    input  logic [SW-1:0]    smp_data,
    input  logic [SW-1:0]    start_lvl,
    input  logic [SUM_W-1:0] stop_lvl,
    input  logic [SUM_W-1:0] win_sum,
    output logic             push,
    output logic             clr,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [SW-1:0]    wr_data,
    output logic [CW-1:0]    cnt,
    output logic             done,
    output logic             ovf
);
    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [SW-1:0] data;
    } wr_req_t;

    phase_e     ph;
    wr_req_t    wr_q;
    logic       accept;
    logic [CW-1:0] cnt_nx;
    logic       win_full;
    logic       hit_stop;
    logic       hit_full;

    always_comb begin
        accept   = smp_valid && !rearm &&
                   (((ph == PH_IDLE) && (smp_data > start_lvl)) || (ph == PH_FILL));
        cnt_nx   = cnt + CW'(1);
        win_full = cnt_nx >= CW'(WIN);
        hit_stop = win_full && (win_sum < stop_lvl);
        hit_full = cnt_nx == CW'(DEPTH);
    end

    assign push = accept;
    assign clr  = rearm;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            done <= 1'b0;
            ovf  <= 1'b0;
            wr_q <= '0;
        end else begin
            wr_q.en <= accept;
            if (accept) begin
                wr_q.addr <= cnt[AW-1:0];
                wr_q.data <= smp_data;
            end
            if (rearm) begin
                ph   <= PH_IDLE;
                cnt  <= '0;
                done <= 1'b0;
                ovf  <= 1'b0;
            end else if (accept) begin
                cnt <= cnt_nx;
                if (hit_stop) begin
                    ph   <= PH_HELD;
                    done <= 1'b1;
                end else if (hit_full) begin
                    ph   <= PH_HELD;
                    done <= 1'b1;
                    ovf  <= 1'b1;
                end else begin
                    ph <= PH_FILL;
                end
            end
        end
    end

    assign wr_en   = wr_q.en;
    assign wr_addr = wr_q.addr;
    assign wr_data = wr_q.data;

    AST_IDLE_DROPS_LOW: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE && smp_valid && !(smp_data > start_lvl)) |=> !wr_en);  // R1

    AST_INVALID_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !wr_en);  // R3

    AST_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_HELD) |=> !wr_en);  // R7

endmodule

// File: rtl/burst_capture_gate.sv
module burst_capture_gate
    import capgate_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned DEPTH    = 2048,
    localparam int unsigned AW      = $clog2(DEPTH),
    localparam int unsigned CW      = $clog2(DEPTH + 1),
    localparam int unsigned SUM_W   = sum_width(SAMPLE_W, WIN_LEN)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [SAMPLE_W-1:0] start_lvl,
    input  logic [SUM_W-1:0]    stop_lvl,
    input  logic                rearm,
    output logic                wr_en,
    output logic [AW-1:0]       wr_addr,
    output logic [SAMPLE_W-1:0] wr_data,
    output logic [CW-1:0]       cap_count,
    output logic                cap_done,
    output logic                cap_ovf
);
    logic             win_push;
    logic             win_clr;
    logic [SUM_W-1:0] win_sum;

    capgate_window #(
        .SW    (SAMPLE_W),
        .WIN   (WIN_LEN),
        .SUM_W (SUM_W)
    ) i_window (
        .clk   (clk),
        .rst   (rst),
        .clr   (win_clr),
        .push  (win_push),
        .din   (smp_data),
        .sum_o (win_sum)
    );

    capgate_ctrl #(
        .SW    (SAMPLE_W),
        .DEPTH (DEPTH),
        .WIN   (WIN_LEN),
        .SUM_W (SUM_W),
        .AW    (AW),
        .CW    (CW)
    ) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .rearm     (rearm),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .start_lvl (start_lvl),
        .stop_lvl  (stop_lvl),
        .win_sum   (win_sum),
        .push      (win_push),
        .clr       (win_clr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cnt       (cap_count),
        .done      (cap_done),
        .ovf       (cap_ovf)
    );

    AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + AW'(1)));  // R2

    AST_WINDOW_FULL_STOP: assert property (@(posedge clk) disable iff (rst)
        (cap_done && !cap_ovf) |-> (cap_count >= CW'(WIN_LEN)));  // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cap_ovf |-> (cap_done && cap_count == CW'(DEPTH)));  // R6

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cap_count <= CW'(DEPTH));  // R6

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cap_done && $past(cap_done) && !$past(rearm)) |->
            ($stable(cap_count) && $stable(cap_ovf)));  // R7

    AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rearm) |-> (!cap_done && !cap_ovf && cap_count == '0 && !wr_en));  // R8

endmodule

// File: tb/test_burst_capture_gate.sv
module test_burst_capture_gate;
    localparam int CLK_PERIOD = 10;
    localparam int SW    = 8;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int CW    = 5;
    localparam int SUMW  = 11;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            smp_valid = 1'b0;
    logic [SW-1:0]   smp_data = '0;
    logic [SW-1:0]   start_lvl = '0;
    logic [SUMW-1:0] stop_lvl = '0;
    logic            rearm = 1'b0;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [SW-1:0]   wr_data;
    logic [CW-1:0]   cap_count;
    logic            cap_done;
    logic            cap_ovf;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench model state
    int m_ph = 0;
    int m_cnt = 0;
    int m_done = 0;
    int m_ovf = 0;
    int m_hist [5];
    int e_we = 0;
    int e_addr = 0;
    int e_data = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_capture_gate #(.SAMPLE_W(SW), .DEPTH(DEPTH)) i_burst_capture_gate (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .start_lvl(start_lvl), .stop_lvl(stop_lvl), .rearm(rearm),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cap_count(cap_count), .cap_done(cap_done), .cap_ovf(cap_ovf)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_ph = 0; m_cnt = 0; m_done = 0; m_ovf = 0;
        for (int i = 0; i < 5; i++) m_hist[i] = 0;
    endtask

    task automatic model_step(input bit v, input int d, input bit rm);
        int s;
        e_we = 0;
        if (rm) begin
            model_clear();
        end else if (v && ((m_ph == 0 && d > int'(start_lvl)) || m_ph == 1)) begin
            e_we = 1; e_addr = m_cnt; e_data = d;
            s = d;
            for (int i = 0; i < 5; i++) s += m_hist[i];
            for (int i = 4; i > 0; i--) m_hist[i] = m_hist[i-1];
            m_hist[0] = d;
            m_cnt++;
            if (m_cnt >= 6 && s < int'(stop_lvl)) begin
                m_ph = 2; m_done = 1;
            end else if (m_cnt == DEPTH) begin
                m_ph = 2; m_done = 1; m_ovf = 1;
            end else begin
                m_ph = 1;
            end
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "wr_en", int'(wr_en), e_we);
        if (e_we != 0) begin
            chk(tag, "wr_addr", int'(wr_addr), e_addr);
            chk(tag, "wr_data", int'(wr_data), e_data);
        end
        chk(tag, "cap_count", int'(cap_count), m_cnt);
        chk(tag, "cap_done", int'(cap_done), m_done);
        chk(tag, "cap_ovf", int'(cap_ovf), m_ovf);
    endtask

    // Called at a negedge; drives one cycle, checks after the edge.
    task automatic step(input string tag, input bit v, input int d, input bit rm);
        smp_valid = v;
        smp_data  = SW'(d);
        rearm     = rm;
        @(posedge clk);
        model_step(v, d, rm);
        #1;
        check_all(tag);
        @(negedge clk);
    endtask

    task automatic do_rearm(input string tag);
        step(tag, 1'b0, 0, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        // R9: outputs during reset
        chk("R9", "wr_en", int'(wr_en), 0);
        chk("R9", "cap_count", int'(cap_count), 0);
        chk("R9", "cap_done", int'(cap_done), 0);
        chk("R9", "cap_ovf", int'(cap_ovf), 0);
        rst = 1'b0;
        step("R9", 1'b0, 0, 1'b0);

        // R1: low and equal samples ignored while idle
        start_lvl = 8'd100;
        stop_lvl  = 11'd200;
        step("R1", 1'b1, 0, 1'b0);
        step("R1", 1'b1, 50, 1'b0);
        step("R1", 1'b1, 99, 1'b0);
        step("R1", 1'b1, 100, 1'b0);
        // R3: invalid high sample does not start a capture
        step("R3", 1'b0, 250, 1'b0);

        // R2 / R5: start at 150, then zeros; window sum 150 < 200 from the
        // second sample, but the stop only lands on the sixth
        step("R2", 1'b1, 150, 1'b0);
        step("R2", 1'b1, 0, 1'b0);
        step("R3", 1'b0, 0, 1'b0);
        step("R5", 1'b1, 0, 1'b0);
        step("R5", 1'b1, 0, 1'b0);
        step("R5", 1'b1, 0, 1'b0);
        step("R5", 1'b1, 0, 1'b0);
        chk("R5", "count at stop", int'(cap_count), 6);

        // R7: samples after completion
        step("R7", 1'b1, 255, 1'b0);
        step("R7", 1'b1, 0, 1'b0);
        step("R7", 1'b1, 180, 1'b0);

        // R8: rearm clears; rearm with a coincident sample drops it
        do_rearm("R8");
        step("R8", 1'b1, 200, 1'b1);
        chk("R8", "count after rearm", int'(cap_count), 0);

        // R4: stop equal to sum does not stop; one above does
        stop_lvl = 11'd120;
        step("R4", 1'b1, 120, 1'b0);
        for (int i = 0; i < 5; i++) step("R4", 1'b1, 0, 1'b0);
        step("R4", 1'b1, 0, 1'b0);
        chk("R4", "stop on sum below", int'(cap_count), 7);

        // R8: rearm mid-capture abandons and the window forgets old samples
        do_rearm("R8");
        stop_lvl = 11'd300;
        step("R8", 1'b1, 250, 1'b0);
        step("R8", 1'b1, 250, 1'b0);
        do_rearm("R8");
        step("R8", 1'b1, 101, 1'b0);
        for (int i = 0; i < 6; i++) step("R8", 1'b1, 20, 1'b0);

        // R6: buffer fills without stop
        do_rearm("R6");
        start_lvl = 8'd0;
        stop_lvl  = 11'd0;
        for (int i = 0; i < DEPTH + 3; i++) step("R6", 1'b1, 255, 1'b0);
        chk("R6", "overflow count", int'(cap_count), DEPTH);
        chk("R6", "overflow flag", int'(cap_ovf), 1);

        // R6: stop on the final slot wins over overflow
        do_rearm("R6");
        stop_lvl = 11'd1;
        for (int i = 0; i < 10; i++) step("R6", 1'b1, 200, 1'b0);
        for (int i = 0; i < 6; i++) step("R6", 1'b1, 0, 1'b0);
        chk("R6", "stop priority ovf", int'(cap_ovf), 0);
        chk("R6", "stop priority done", int'(cap_done), 1);

        // R4 / R5 / R3 sweep: stop levels against varied burst shapes
        for (int sl = 0; sl < 1600; sl += 53) begin
            for (int seed = 1; seed <= 8; seed++) begin
                do_rearm("R4");
                start_lvl = SW'(seed * 11);
                stop_lvl  = SUMW'(sl);
                for (int k = 0; k < 22; k++) begin
                    int val;
                    val = ((k * (seed * 37 + 13)) + seed * 71) % 256;
                    if (k > 8) val = val / (k - 7);
                    step((k % 5 == 3) ? "R3" : "R4", (k % 5 != 3), val, 1'b0);
                end
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule